// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog with two down-counting stages that run one after the other. Software programs a preload value for each stage and keeps the system alive by restarting the count. If the first stage runs out, an interrupt can be raised. If the second stage then also runs out, a sticky timeout flag is set and a one-cycle reset request is driven out to the system reset logic.

The preload registers and the restart/flag register are guarded. Two magic values must be written back to back to the restart register first. That unlocking sequence admits exactly one protected write. A separate control port holds the enable, mode and lock bits. Once the lock bit is set, that port freezes until the next hardware reset. A configuration port chooses between a slow and a fast decrement tick, picks the interrupt type and can mask the reset request.

Time per stage is (preload + 1) ticks. The slow tick is the clock divided by 2^DIV_SLOW, and the fast tick is the clock divided by 2^DIV_FAST.

Top module: `dual_stage_wdt`

## Requirements
- R1: A write to a protected offset (0x00 stage-1 preload, 0x04 stage-2 preload, 0x0C restart) takes effect only right after the unlock sequence. The sequence is 0x80 then 0x86 in bits 7:0 of consecutive writes to 0x0C. It admits exactly one such write; writes to protected offsets without it are ignored.
- R2: After 0x80, any bus write other than 0x86 (or a repeated 0x80) to offset 0x0C abandons the sequence, and a later 0x86 alone does not unlock.
- R3: An admitted write to 0x0C with bit 8 set restarts stage 1 from its preload and resets the tick divider. A restart that lands in the same cycle as an expiry wins, so no expiry takes place.
- R4: Stage 1 expires (preload1 + 1) ticks after a restart. On expiry, interrupt status bit 0 at 0x08 (and pin irq) is set unless configuration bits 1:0 equal 11. Writing 1 to bit 0 at 0x08 clears it without unlocking, but a set in the same cycle wins over the clear.
- R5: Stage 2 starts at stage-1 expiry and expires (preload2 + 1) ticks later. Its expiry sets the timeout flag, and it pulses rst_out high for one cycle when configuration bit 5 is 0. With bit 5 = 1, the flag is still set but rst_out stays low.
- R6: The timeout flag reads as bit 9 of 0x0C, and all other bits of 0x0C read as 0. It is cleared only by an admitted write to 0x0C with bit 9 set, and bit 8 may be set in the same write.
- R7: Configuration bit 2 = 0 ticks every 2^DIV_SLOW clocks, and 1 ticks every 2^DIV_FAST clocks.
- R8: Counting happens only while control bit 1 (enable) is 1. Clearing it freezes both stages and keeps the timeout flag.
- R9: Once control bit 0 (lock) is 1, control writes are ignored, so enable and lock hold until reset.
- R10: With control bit 2 = 1 (plain timer mode), stage-2 expiry sets neither the flag nor rst_out.
- R11: Reads never start, consume or abandon the unlock sequence.
- R12: After reset, both preloads equal PRE_RST, the flag, interrupt status, rst_out and all control bits are 0, and configuration selects the slow tick with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Byte offset of register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data for bus_addr |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration: bit 5 reset mask, bit 2 fast tick, bits 1:0 interrupt type |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control: bit 0 lock, bit 1 enable, bit 2 timer mode |
| ctl_state | output | 3 | Current control bits |
| irq | output | 1 | Stage-1 interrupt |
| rst_out | output | 1 | One-cycle reset request on stage-2 expiry |

## Verification
Two collisions are provoked on purpose, because their outcome depends on priority. In the first, the bench times an interrupt-clear write so that it commits on the exact edge where stage 1 expires; the status must stay set. In the second, it places an admitted restart on the expiry edge; no interrupt may appear, and the next one must arrive a full stage-1 period after that restart. Both edges come from the tick arithmetic, and the expected cycle counts are derived independently in the bench.

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt #(
  parameter int PRE_W    = 20,
  parameter int DIV_SLOW = 15,
  parameter int DIV_FAST = 5,
  parameter int PRE_RST  = 15360
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  input  logic        ctl_we,
  input  logic [2:0]  ctl_wdata,
  output logic [2:0]  ctl_state,
  output logic        irq,
  output logic        rst_out
);

  localparam logic [1:0] A_PRE1 = 2'd0, A_PRE2 = 2'd1, A_STAT = 2'd2, A_RLD = 2'd3;
  localparam logic [7:0] KEY_A = 8'h80, KEY_B = 8'h86;
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RST);

  typedef enum logic [1:0] {U_IDLE, U_HALF, U_OPEN} ustate_t;

  ustate_t ust;
  logic [PRE_W-1:0] pre1, pre2, cnt;
  logic [DIV_SLOW-1:0] presc;
  logic stage, flag, irq_st, rst_q;
  logic lock_q, en_q, func_q;
  logic cfg_nrst, cfg_fast;
  logic [1:0] cfg_type;
  logic [31:0] wmerge;

  wire [1:0] sel     = bus_addr[3:2];
  wire rld_wr        = bus_we && sel == A_RLD;
  wire prot_wr       = bus_we && sel != A_STAT;
  wire open_wr       = prot_wr && ust == U_OPEN;
  wire key_a         = rld_wr && bus_be[0] && bus_wdata[7:0] == KEY_A;
  wire key_b         = rld_wr && bus_be[0] && bus_wdata[7:0] == KEY_B;
  wire reload        = open_wr && sel == A_RLD && bus_be[1] && bus_wdata[8];
  wire flag_clr      = open_wr && sel == A_RLD && bus_be[1] && bus_wdata[9];
  wire irq_clr       = bus_we && sel == A_STAT && bus_be[0] && bus_wdata[0];
  wire tick          = en_q && (cfg_fast ? &presc[DIV_FAST-1:0] : &presc);
  wire expire        = tick && cnt == '0 && !reload;
  wire [PRE_W-1:0] cur = sel[0] ? pre2 : pre1;
  wire [31:0] old32  = 32'(cur);
  wire unused_ok     = ^{bus_addr[1:0], cfg_wdata[7:6], cfg_wdata[4:3], wmerge};

  always_comb
    for (int b = 0; b < 4; b++)
      wmerge[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : old32[8*b +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ust <= U_IDLE;
    else if (bus_we)
      case (ust)
        U_IDLE:  if (key_a) ust <= U_HALF;
        U_HALF:  ust <= key_b ? U_OPEN : (key_a ? U_HALF : U_IDLE);
        U_OPEN:  if (prot_wr) ust <= U_IDLE;
        default: ust <= U_IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre1 <= PRE_INIT;
      pre2 <= PRE_INIT;
    end else if (open_wr) begin
      if (sel == A_PRE1) pre1 <= wmerge[PRE_W-1:0];
      if (sel == A_PRE2) pre2 <= wmerge[PRE_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= PRE_INIT;
      stage <= 1'b0;
      presc <= '0;
    end else if (reload) begin
      cnt   <= pre1;
      stage <= 1'b0;
      presc <= '0;
    end else if (en_q) begin
      presc <= presc + 1'b1;
      if (tick) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!stage) begin
          stage <= 1'b1;
          cnt   <= pre2;
        end else begin
          stage <= 1'b0;
          cnt   <= pre1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag   <= 1'b0;
      irq_st <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (expire && stage && !func_q) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (expire && !stage && cfg_type != 2'b11) irq_st <= 1'b1;
      else if (irq_clr) irq_st <= 1'b0;
      rst_q <= expire && stage && !func_q && !cfg_nrst;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {func_q, en_q, lock_q} <= 3'b000;
    else if (ctl_we && !lock_q) {func_q, en_q, lock_q} <= ctl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_nrst <= 1'b0;
      cfg_fast <= 1'b0;
      cfg_type <= 2'b11;
    end else if (cfg_we) begin
      cfg_nrst <= cfg_wdata[5];
      cfg_fast <= cfg_wdata[2];
      cfg_type <= cfg_wdata[1:0];
    end

  always_comb
    case (sel)
      A_PRE1:  bus_rdata = 32'(pre1);
      A_PRE2:  bus_rdata = 32'(pre2);
      A_STAT:  bus_rdata = {31'b0, irq_st};
      default: bus_rdata = {22'b0, flag, 9'b0};
    endcase

  assign ctl_state = {func_q, en_q, lock_q};
  assign irq       = irq_st;
  assign rst_out   = rst_q;

  p_locked_pre1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == A_PRE1 && ust != U_OPEN) |=> $stable(pre1));
  p_abandon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ust == U_HALF && bus_we && sel != A_RLD) |=> ust == U_IDLE);
  p_irq_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cfg_type) != 2'b11);
  p_rst_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> flag);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reload) |=> ($stable(cnt) && $stable(stage)));
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(en_q)));
  p_timer_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(func_q));
  p_read_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(ust));

endmodule

// File: tb/dual_stage_wdt_tb.sv
`timescale 1ns/1ps
module dual_stage_wdt_tb;
  localparam int DS = 3, DF = 1, PR = 100;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0, bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_we = 0, cfg_we = 0, ctl_we = 0, irq, rst_out;
  logic [7:0] cfg_wdata = 0;
  logic [2:0] ctl_wdata = 0, ctl_state;
  int n_chk = 0, n_fail = 0;

  dual_stage_wdt #(.PRE_W(20), .DIV_SLOW(DS), .DIV_FAST(DF), .PRE_RST(PR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_state(ctl_state), .irq(irq), .rst_out(rst_out));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); bus_addr = a; #1 d = int'(bus_rdata);
  endtask

  task automatic unlock();
    wr(4'hC, 32'h80); wr(4'hC, 32'h86);
  endtask

  task automatic ctl(input logic [2:0] v);
    @(negedge clk); ctl_wdata = v; ctl_we = 1; @(posedge clk); #1 ctl_we = 0;
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1; @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // preload both stages, then restart; returns after the irq-clear write (c = 1)
  task automatic start(input int n1, input int n2);
    unlock(); wr(4'h0, n1);
    unlock(); wr(4'h4, n2);
    unlock(); wr(4'hC, 32'h300, 4'b0011);
    wr(4'h8, 1, 4'b0001);
  endtask

  task automatic run_case(input int n1, input int n2, input bit fast, input bit nrst);
    int p, c, irq_at, rst_at, rst_n_hi, lim, d;
    p = fast ? 2 ** DF : 2 ** DS;
    cfg(8'((int'(nrst) << 5) | (int'(fast) << 2)));
    ctl(3'b010);
    start(n1, n2);
    c = 1; irq_at = -1; rst_at = -1; rst_n_hi = 0;
    lim = (n1 + n2 + 2) * p + 3;
    while (c < lim) begin
      @(posedge clk); #1 c++;
      if (irq && irq_at < 0) irq_at = c;
      if (rst_out) begin rst_n_hi++; if (rst_at < 0) rst_at = c; end
    end
    chk($sformatf("R4 R7 stage1 expiry n1=%0d fast=%0d", n1, fast), irq_at, (n1 + 1) * p);
    chk($sformatf("R5 reset pulse cycle n1=%0d n2=%0d fast=%0d nrst=%0d", n1, n2, fast, nrst),
        rst_at, nrst ? -1 : (n1 + n2 + 2) * p);
    chk("R5 reset pulse width", rst_n_hi, nrst ? 0 : 1);
    rd(4'hC, d);
    chk("R6 timeout flag read", d, 32'h200);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, c;
    cyc(3); @(negedge clk) rst_n = 1;
    // R12 reset state
    chk("R12 irq", irq, 0); chk("R12 rst_out", rst_out, 0); chk("R12 ctl", ctl_state, 0);
    rd(4'h0, d); chk("R12 pre1", d, PR);
    rd(4'h4, d); chk("R12 pre2", d, PR);
    rd(4'hC, d); chk("R12 flag", d, 0);
    // R1 protection and single admitted write
    wr(4'h0, 55); rd(4'h0, d); chk("R1 write without unlock ignored", d, PR);
    unlock(); wr(4'h0, 7); wr(4'h0, 9); rd(4'h0, d); chk("R1 one write per unlock", d, 7);
    // R11 reads do not consume
    unlock(); rd(4'h4, d); rd(4'hC, d); wr(4'h4, 5); rd(4'h4, d); chk("R11 read keeps unlock", d, 5);
    // R2 abandon
    wr(4'hC, 32'h80); wr(4'hC, 32'h44); wr(4'hC, 32'h86); wr(4'h0, 33);
    rd(4'h0, d); chk("R2 wrong key abandons", d, 7);
    wr(4'hC, 32'h80); wr(4'h8, 0); wr(4'hC, 32'h86); wr(4'h0, 34);
    rd(4'h0, d); chk("R2 other write abandons", d, 7);
    wr(4'hC, 32'h80); wr(4'hC, 32'h80); wr(4'hC, 32'h86); wr(4'h0, 35);
    rd(4'h0, d); chk("R2 repeated first key keeps sequence", d, 35);
    // sweep timing: R4 R5 R7
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) run_case(a, b, f[0], 1'b0);
    run_case(1, 0, 1'b1, 1'b1);
    run_case(0, 2, 1'b0, 1'b1);
    // R6 flag clear protection and combined write
    wr(4'hC, 32'h200, 4'b0010); rd(4'hC, d); chk("R6 clear needs unlock", d, 32'h200);
    // R8 disable keeps flag
    ctl(3'b000); rd(4'hC, d); chk("R8 flag kept when disabled", d, 32'h200);
    unlock(); wr(4'hC, 32'h200, 4'b0010); rd(4'hC, d); chk("R6 unlocked clear", d, 0);
    // R8 freeze then resume
    cfg(8'h04); wr(4'h8, 1, 4'b0001);
    unlock(); wr(4'h0, 0); unlock(); wr(4'hC, 32'h100, 4'b0010);
    cyc(40); chk("R8 no expiry while disabled", irq, 0);
    ctl(3'b010); @(posedge clk); #1 chk("R8 resume first cycle", irq, 0);
    @(posedge clk); #1 chk("R8 resume expiry", irq, 1);
    // same-cycle: irq clear vs expiry (R4)
    start(2, 9); cyc(4); wr(4'h8, 1, 4'b0001);
    chk("R4 set beats clear in same cycle", irq, 1);
    // same-cycle: restart vs expiry (R3)
    start(2, 9); cyc(2); unlock(); wr(4'hC, 32'h100, 4'b0010);
    chk("R3 restart beats expiry", irq, 0);
    c = 6;
    while (!irq && c < 40) begin @(posedge clk); #1 c++; end
    chk("R3 restart delay", c, 12);
    // R4 type 11 gives no irq
    cfg(8'h07); start(0, 0); cyc(12);
    chk("R4 type 11 no irq", irq, 0);
    rd(4'hC, d); chk("R5 flag with no irq", d, 32'h200);
    // R10 timer mode
    cfg(8'h04); unlock(); wr(4'hC, 32'h200, 4'b0010); ctl(3'b110);
    c = 0; start(0, 0);
    for (int i = 0; i < 12; i++) begin @(posedge clk); #1 if (rst_out) c++; end
    chk("R10 irq in timer mode", irq, 1); chk("R10 no rst_out", c, 0);
    rd(4'hC, d); chk("R10 no flag", d, 0);
    // R9 lock
    ctl(3'b011); ctl(3'b000); chk("R9 lock freezes control", ctl_state, 3);
    ctl(3'b100); chk("R9 lock freezes mode", ctl_state, 3);
    @(negedge clk) rst_n = 0; cyc(2); @(negedge clk) rst_n = 1;
    chk("R12 reset releases lock", ctl_state, 0);
    rd(4'h0, d); chk("R12 pre1 after reset", d, PR);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule